// File: doc/BRIEF.md
# Taylor-Corrected Quadrature Sine Oscillator

This block is a numerically controlled oscillator that produces a sine and a cosine sample every enabled clock. A 32-bit phase register steps by a tuning word each enabled cycle and wraps modulo 2^32. The leading twelve phase bits give a coarse angle. The two leading bits pick the quadrant and the next ten index a table holding one quarter of a wave. The eight bits below them are a fractional offset inside one table step.

One read port looks up the sine of the coarse angle. A second port of the same table looks up the angle a quarter turn ahead, which is the cosine. Each port folds its own address. The cosine then serves as the slope of the sine and the negated sine as the slope of the cosine. Each slope is multiplied by the fractional angle, rounded and added to its base value, which is a first-order Taylor step. To save table width, each entry holds only the gap between the sine and a straight chord rising to full scale. The chord is added back after the read. A mode input turns the correction off, so that the output is the plain coarse lookup.

Top module: `dds_taylor_sine`

## Requirements
- R1: Reset (synchronous, active high) drives `valid`, `sine` and `cosine` to 0 and sets the phase to zero. The first valid sample after reset is therefore sine 0 and cosine 8191.
- R2: Counting valid samples from 0 after reset, sample k belongs to phase p = k*tuning_word mod 2^32. Phase bits 31:30 select the quadrant, bits 29:20 the table step and bits 19:12 the fractional offset.
- R3: `valid` carries the value that `en` had at the rising edge three edges earlier. An enable sampled at edge E shows as valid after edge E+2.
- R4: While `en` is low the phase holds and no valid sample is produced. When `en` returns, the samples continue the sequence of R2 with no gap in k.
- R5: At phases 0, 2^30, 2^31 and 3*2^30 the outputs (sine, cosine) are exactly (0, 8191), (8191, 0), (0, -8191) and (-8191, 0).
- R6: With `interp_en` low, `sine` is within 1 LSB of 8191*sin(2*pi*c/4096), where c is phase bits 31:20.
- R7: With `interp_en` high, `sine` is within 2 LSB of 8191*sin(2*pi*p/2^32).
- R8: `cosine` meets the tolerance of R6 or R7, according to the mode, against 8191*cos of the same angle.
- R9: Outputs are saturated to the symmetric range -8191..8191, so -8192 never appears. For a valid sample, sine^2+cosine^2 stays within 8*8191 of 8191^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the phase and launch a sample this cycle |
| interp_en | input | 1 | 1: apply the slope correction; 0: plain coarse lookup |
| tuning_word | input | 32 | Phase increment per enabled cycle |
| sine | output | 14 | Signed sine sample |
| cosine | output | 14 | Signed cosine sample |
| valid | output | 1 | The sample on `sine`/`cosine` is valid |

## Verification
A zero tuning word holds the phase at zero, which isolates the reset phase and the cosine peak. Quarter-turn steps land exactly on the quadrant boundaries, which separates a correct fold from an off-by-one mirror. Irregular steps with nonzero fractional bits, tried in both modes, tell a real slope correction apart from a truncated lookup, since the plain lookup drifts by up to about 12 LSB. A step of all ones exercises wrap-around and negative angles, and a burst with the enable dropped shows that the phase holds and that valid tracks the enable three edges late.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // pi scaled by 2^30
    localparam longint PI_Q30 = 64'sd3373259426;
    // pi with 13 fractional bits, for the slope step
    localparam int PI_FRAC = 13;
    localparam int PI_QS   = int'((PI_Q30 + (64'sd1 <<< (29 - PI_FRAC))) >>> (30 - PI_FRAC));

    typedef enum logic [1:0] {
        Q_RISE   = 2'd0,
        Q_CREST  = 2'd1,
        Q_FALL   = 2'd2,
        Q_TROUGH = 2'd3
    } quad_e;

    // sine of an angle in [0, pi/2], both in Q30, by odd power series
    function automatic longint sin_q30(input longint x);
        longint x2;
        longint term;
        longint acc;
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 6; k++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // table word: rounded amp*sin(idx*pi/2^(addr_w+1)) minus the chord idx<<line_sh
    function automatic longint tbl_entry(input int idx, input int addr_w,
                                         input int amp, input int line_sh);
        longint x;
        longint s;
        longint v;
        x = (longint'(idx) * PI_Q30 + (64'sd1 <<< addr_w)) >>> (addr_w + 1);
        s = sin_q30(x);
        v = (s * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
        return v - (longint'(idx) <<< line_sh);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int LEAD_W  = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] step,
    output logic [LEAD_W-1:0]  lead
);
    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_q + step;
    end

    assign lead = acc_q[PHASE_W-1 -: LEAD_W];
endmodule

// File: rtl/dds_fold.sv
module dds_fold
    import dds_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W+1:0] coarse,
    output logic [ADDR_W:0]   addr,
    output logic              neg
);
    localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};

    quad_e            quad;
    logic [ADDR_W:0]  step;
    logic             mirror;

    always_comb begin
        quad   = quad_e'(coarse[ADDR_W+1:ADDR_W]);
        step   = {1'b0, coarse[ADDR_W-1:0]};
        mirror = (quad == Q_CREST) || (quad == Q_TROUGH);
        neg    = (quad == Q_FALL)  || (quad == Q_TROUGH);
        addr   = mirror ? (FULL - step) : step;
    end
endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom
    import dds_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 12,
    parameter int AMP     = 8191,
    parameter int LINE_SH = 3
) (
    input  logic                     clk,
    input  logic [ADDR_W:0]          addr_a,
    input  logic [ADDR_W:0]          addr_b,
    output logic signed [DATA_W-1:0] data_a,
    output logic signed [DATA_W-1:0] data_b
);
    // both end points of the quarter are stored, so mirroring needs no offset
    localparam int DEPTH = (1 << ADDR_W) + 1;

    logic signed [DATA_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = DATA_W'(tbl_entry(i, ADDR_W, AMP, LINE_SH));
    end

    always_ff @(posedge clk) begin
        data_a <= mem[addr_a];
        data_b <= mem[addr_b];
    end
endmodule

// File: rtl/dds_taylor.sv
module dds_taylor
    import dds_pkg::*;
#(
    parameter int OUT_W    = 14,
    parameter int FRAC_W   = 8,
    parameter int ANGLE_SH = 19,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OUT_W:0]   base,
    input  logic signed [OUT_W:0]   slope,
    input  logic [FRAC_W-1:0]       frac,
    input  logic                    interp,
    output logic signed [OUT_W-1:0] y
);
    localparam int PROD_W = OUT_W + FRAC_W + 2;
    localparam int WIDE_W = PROD_W + 16;
    localparam int SHIFT  = ANGLE_SH + PI_FRAC;

    localparam logic signed [WIDE_W-1:0] PI_K    = WIDE_W'(PI_QS);
    localparam logic signed [WIDE_W-1:0] ROUND_K = {{(WIDE_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
    localparam logic signed [WIDE_W-1:0] MAX_K   = WIDE_W'((1 << (OUT_W-1)) - 1);
    localparam logic signed [WIDE_W-1:0] MIN_K   = -MAX_K;

    logic signed [OUT_W:0]    base_q;
    logic signed [PROD_W-1:0] prod_q;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [WIDE_W-1:0] corr;
    logic signed [WIDE_W-1:0] base_w;
    logic signed [WIDE_W-1:0] sum;

    // stage B: base value and slope times fraction
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            prod_q <= '0;
        end else begin
            base_q <= base;
            prod_q <= interp ? PROD_W'(slope) * PROD_W'($signed({1'b0, frac})) : '0;
        end
    end

    always_comb begin
        scaled = WIDE_W'(prod_q) * PI_K;
        corr   = (scaled + ROUND_K) >>> SHIFT;
        base_w = WIDE_W'(base_q);
    end

    if (SUBTRACT) begin : g_sub
        assign sum = base_w - corr;
    end else begin : g_add
        assign sum = base_w + corr;
    end

    // stage C: saturate into the symmetric output range
    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (sum > MAX_K)
            y <= MAX_K[OUT_W-1:0];
        else if (sum < MIN_K)
            y <= MIN_K[OUT_W-1:0];
        else
            y <= sum[OUT_W-1:0];
    end
endmodule

// File: rtl/dds_taylor_sine.sv
module dds_taylor_sine
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int FRAC_W  = 8,
    parameter int OUT_W   = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    interp_en,
    input  logic [PHASE_W-1:0]      tuning_word,
    output logic signed [OUT_W-1:0] sine,
    output logic signed [OUT_W-1:0] cosine,
    output logic                    valid
);
    localparam int COARSE_W = ADDR_W + 2;
    localparam int LEAD_W   = COARSE_W + FRAC_W;
    localparam int LINE_SH  = OUT_W - 1 - ADDR_W;
    localparam int AMP      = (1 << (OUT_W - 1)) - 1;
    // sine minus chord peaks near 0.21 of full scale: two bits fewer than the output
    localparam int TBL_W    = OUT_W - 2;
    localparam int LAT      = 3;

    logic [LEAD_W-1:0]         phase_q;
    logic [COARSE_W-1:0]       coarse [2];
    logic [ADDR_W:0]           addr   [2];
    logic                      neg    [2];
    logic signed [TBL_W-1:0]   tbl    [2];
    logic [ADDR_W:0]           addr_q [2];
    logic                      neg_q  [2];
    logic [FRAC_W-1:0]         frac_q;
    logic                      interp_q;
    logic signed [OUT_W:0]     mag    [2];
    logic signed [OUT_W:0]     recon  [2];
    logic signed [OUT_W-1:0]   y      [2];
    logic [LAT-1:0]            vld_q;

    dds_phase_acc #(.PHASE_W(PHASE_W), .LEAD_W(LEAD_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .step (tuning_word),
        .lead (phase_q)
    );

    // port 0 reads the sine, port 1 the angle a quarter turn ahead
    assign coarse[0] = phase_q[LEAD_W-1 -: COARSE_W];
    assign coarse[1] = coarse[0] + {2'b01, {ADDR_W{1'b0}}};

    for (genvar p = 0; p < 2; p++) begin : g_fold
        dds_fold #(.ADDR_W(ADDR_W)) u_fold (
            .coarse (coarse[p]),
            .addr   (addr[p]),
            .neg    (neg[p])
        );
    end

    dds_quarter_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (TBL_W),
        .AMP    (AMP),
        .LINE_SH(LINE_SH)
    ) u_rom (
        .clk    (clk),
        .addr_a (addr[0]),
        .addr_b (addr[1]),
        .data_a (tbl[0]),
        .data_b (tbl[1])
    );

    // stage A: side information that travels beside the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q   <= '0;
            interp_q <= 1'b0;
            vld_q    <= '0;
            for (int p = 0; p < 2; p++) begin
                addr_q[p] <= '0;
                neg_q[p]  <= 1'b0;
            end
        end else begin
            frac_q   <= phase_q[FRAC_W-1:0];
            interp_q <= interp_en;
            vld_q    <= {vld_q[LAT-2:0], en};
            for (int p = 0; p < 2; p++) begin
                addr_q[p] <= addr[p];
                neg_q[p]  <= neg[p];
            end
        end
    end

    // add the chord back, then apply the quadrant sign
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            mag[p]   = {{(OUT_W+1-TBL_W){tbl[p][TBL_W-1]}}, tbl[p]}
                     + $signed({1'b0, addr_q[p], {LINE_SH{1'b0}}});
            recon[p] = neg_q[p] ? -mag[p] : mag[p];
        end
    end

    // sine slope is +cosine; cosine slope is -sine
    for (genvar p = 0; p < 2; p++) begin : g_corr
        dds_taylor #(
            .OUT_W   (OUT_W),
            .FRAC_W  (FRAC_W),
            .ANGLE_SH(ADDR_W + 1 + FRAC_W),
            .SUBTRACT(p == 1)
        ) u_taylor (
            .clk    (clk),
            .rst    (rst),
            .base   (recon[p]),
            .slope  (recon[1-p]),
            .frac   (frac_q),
            .interp (interp_q),
            .y      (y[p])
        );
    end

    assign sine   = y[0];
    assign cosine = y[1];
    assign valid  = vld_q[LAT-1];
endmodule

// File: rtl/dds_taylor_sine_chk.sv
module dds_taylor_sine_chk #(
    parameter int LEAD_W = 20,
    parameter int OUT_W  = 14
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic                    valid,
    input logic signed [OUT_W-1:0] sine,
    input logic signed [OUT_W-1:0] cosine,
    input logic [LEAD_W-1:0]       phase
);
    localparam longint AMP   = longint'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

    logic [1:0] age;
    longint     pwr;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    always_comb pwr = longint'(sine) * longint'(sine) + longint'(cosine) * longint'(cosine);

    // R1: the cycle after reset shows cleared outputs
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid && sine == '0 && cosine == '0));

    // R3: valid follows en three edges later
    a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (valid == $past(en, 3)));

    // R4: with en low the phase holds
    a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase));

    // R9: never the asymmetric negative code
    a_r9_no_neg_full: assert property (@(posedge clk) disable iff (rst)
        valid |-> (sine != NEG_FULL && cosine != NEG_FULL));

    // R9: quadrature pair stays on the circle
    a_r9_amplitude: assert property (@(posedge clk) disable iff (rst)
        valid |-> (pwr <= AMP * AMP + 8 * AMP && pwr >= AMP * AMP - 8 * AMP));
endmodule

bind dds_taylor_sine dds_taylor_sine_chk #(
    .LEAD_W(LEAD_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .valid (valid),
    .sine  (sine),
    .cosine(cosine),
    .phase (phase_q)
);

// File: tb/tb_dds_taylor_sine.sv
`timescale 1ns/1ps
module tb_dds_taylor_sine;
    localparam real TWO_PI = 6.283185307179586;
    localparam real AMPR   = 8191.0;

    typedef struct packed {
        logic [31:0] tw;
        logic        interp;
        logic [7:0]  ncyc;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 1'b1, 8'd6},
        '{32'h0012_3457, 1'b1, 8'd60},
        '{32'h0012_3457, 1'b0, 8'd60},
        '{32'h3FFF_F0FF, 1'b1, 8'd40},
        '{32'hFFFF_FFFF, 1'b1, 8'd30},
        '{32'h000A_5000, 1'b1, 8'd60},
        '{32'h8000_0000, 1'b0, 8'd8}
    };
    localparam string VTAG [NV] = '{"R1", "R7", "R6", "R7", "R2", "R7", "R6"};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en = 1'b0;
    logic               interp_en = 1'b1;
    logic [31:0]        tuning_word = '0;
    logic signed [13:0] sine;
    logic signed [13:0] cosine;
    logic               valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dds_taylor_sine dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .interp_en  (interp_en),
        .tuning_word(tuning_word),
        .sine       (sine),
        .cosine     (cosine),
        .valid      (valid)
    );

    task automatic check_eq(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic check_near(input string tag, input int act, input real expv, input real tol);
        checks++;
        if ((real'(act) - expv) > tol || (expv - real'(act)) > tol) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0.3f", tag, act, expv);
        end
    endtask

    function automatic real ideal(input logic [31:0] p, input logic ip, input bit is_cos);
        real ang;
        if (ip)
            ang = TWO_PI * real'(longint'({32'd0, p})) / 4294967296.0;
        else
            ang = TWO_PI * real'(int'({20'd0, p[31:20]})) / 4096.0;
        return is_cos ? AMPR * $cos(ang) : AMPR * $sin(ang);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        en  = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: cleared state seen at the ports
        check_eq("R1 valid after reset", int'(valid), 0);
        check_eq("R1 sine after reset", int'(sine), 0);
        check_eq("R1 cosine after reset", int'(cosine), 0);
    endtask

    // runs ncyc enabled cycles except [plo,phi], then drains the pipeline
    task automatic stream(input logic [31:0] t, input logic ip, input int ncyc,
                          input int plo, input int phi, input string tag);
        logic [2:0]  hist = '0;
        logic [31:0] ph;
        int          k = 0;
        real         tol;
        tol = ip ? 2.0 : 1.0;
        do_reset();
        tuning_word = t;
        interp_en   = ip;
        for (int c = 0; c < ncyc + 3; c++) begin
            en   = (c < ncyc) && !(c >= plo && c <= phi);
            hist = {hist[1:0], en};
            @(negedge clk);
            check_eq("R3 valid latency", int'(valid), int'(hist[2]));
            if (valid) begin
                ph = t * 32'(k);
                check_near({tag, " sine"}, int'(sine), ideal(ph, ip, 1'b0), tol);
                check_near("R8 cosine", int'(cosine), ideal(ph, ip, 1'b1), tol);
                checks++;
                if (sine > 14'sd8191 || sine < -14'sd8191 || cosine < -14'sd8191) begin
                    failures++;
                    $display("FAIL R9 range actual=%0d/%0d expected=within 8191", sine, cosine);
                end
                k++;
            end
        end
    endtask

    localparam int QS [5] = '{0, 8191, 0, -8191, 0};
    localparam int QC [5] = '{8191, 0, -8191, 0, 8191};

    initial begin
        // vector walk
        for (int vi = 0; vi < NV; vi++)
            stream(VECS[vi].tw, VECS[vi].interp, int'(VECS[vi].ncyc), 1, 0, VTAG[vi]);

        // R4: pause in the middle; sequence must continue without a gap
        stream(32'h0137_9ABD, 1'b1, 40, 12, 19, "R4");
        stream(32'h0137_9ABD, 1'b0, 30, 5, 5, "R4");

        // R5: exact quarter points, first sample also covers R1
        do_reset();
        tuning_word = 32'h4000_0000;
        interp_en   = 1'b1;
        en          = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check_eq("R5 valid", int'(valid), 1);
            check_eq(i == 0 ? "R1 first sine" : "R5 sine", int'(sine), QS[i]);
            check_eq(i == 0 ? "R1 first cosine" : "R5 cosine", int'(cosine), QC[i]);
            @(negedge clk);
        end
        en = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R4 no sample while idle", int'(valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule